// File: doc/BRIEF.md
# Parallel Flash Command Front End

This block models the command and status side of a 16-bit-wide parallel NOR flash. A host drives active-low chip-enable, write-enable and output-enable together with an address bus and a data bus. The block watches these signals and turns qualified write strobes into steps of a guarded command sequence. A completed sequence starts a program of one word or an erase of a sector, a block or the whole array. A small register file stands in for the cell array.

Each operation occupies a busy phase whose length is a parameter in clock cycles. During that phase a read returns a status word instead of array data. Bit 7 reports progress and bit 6 flips on every new read. A host polls either bit to learn when the operation has finished. All strobes are sampled on the system clock. A strobe counts as a write only when it stays low for a minimum number of clock cycles.

The sequencer is one state machine with these states:
- `ST_IDLE`: read mode.
- `ST_UNL1` and `ST_UNL2`: the first and second unlock writes have been seen.
- `ST_PRG_WAIT`: the program command has been seen and the word to program is awaited.
- `ST_ERS_SET`: the erase-arm command has been seen.
- `ST_ERS_UNL1` and `ST_ERS_UNL2`: the second unlock pair has been seen.
- `ST_BUSY_PRG` and `ST_BUSY_ERS`: the busy phases.

The transitions are:
- `ST_IDLE` → `ST_UNL1` on the first key.
- `ST_UNL1` → `ST_UNL2` on the second key.
- `ST_UNL2` → `ST_PRG_WAIT` on the program command, or `ST_UNL2` → `ST_ERS_SET` on the erase-arm command.
- `ST_PRG_WAIT` → `ST_BUSY_PRG` on any write.
- `ST_ERS_SET` → `ST_ERS_UNL1` on the first key.
- `ST_ERS_UNL1` → `ST_ERS_UNL2` on the second key.
- `ST_ERS_UNL2` → `ST_BUSY_ERS` on a valid erase confirm.
- From either busy state back to `ST_IDLE` when the busy count expires.
- Every unexpected write in an unlock or arm state returns the machine to `ST_IDLE`.

Top module: `flash_cmd_emu`

## Requirements
- R1: After reset every array word reads 0xFFFF, no operation is busy, and `dout` is 0 whenever no read is in progress.
- R2: A word program needs four writes in this order: 0xAA to address 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then the target address and data. Commands are compared on data bits 7:0, and addresses on all 16 bits. The array word selected by the low log2(WORDS) address bits is updated when the busy phase ends.
- R3: Programming only clears bits: the stored word becomes the old value AND the new data.
- R4: Inside the program sequence, a write whose address or command does not match the next expected step aborts the sequence to read mode. Later writes then start nothing.
- R5: No write is recognised while `oe_n` is low or `ce_n` is high, even with `we_n` low.
- R6: A write strobe (ce_n, we_n low and oe_n high) must last at least MIN_PULSE clock edges to count. A shorter strobe is ignored and leaves the sequence state unchanged.
- R7: During a program, a read returns a status word with bit 7 equal to the inverse of bit 7 of the programmed data. Bit 6 flips at the start of each new read. All other bits are 0.
- R8: Let k be the first clock edge that samples the final strobe inactive. Status is returned from edge k+1 for exactly PRG_CYCLES cycles for a program, or ERS_CYCLES cycles for an erase. After that, reads return array data.
- R9: A sector erase is 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at any address. It sets the SEC_WORDS-aligned group containing that address to 0xFFFF. While busy, status bit 7 reads 0 and bit 6 flips on each read.
- R10: The same five writes followed by 0x50 at any address set the BLK_WORDS-aligned group containing that address to 0xFFFF.
- R11: The same five writes followed by 0x10 at address 0x5555 set every array word to 0xFFFF.
- R12: Writes made while an operation is busy are ignored and do not advance any sequence.
- R13: Inside the erase sequence, a wrong step or an unknown confirm code aborts to read mode without changing the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock on which all strobes are sampled |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or status word; 0 when not reading |

## Verification
Let k be the first edge that sees a strobe inactive. The write is registered at that edge, the state machine moves at edge k+1, and busy ends at edge k+1+PRG_CYCLES (or ERS_CYCLES). The bench therefore samples its first status read two negative edges after releasing the final strobe. For the program timing boundary, it reads at the negative edge just before the last busy edge and again at the edge after it.

Read data is combinational from the ports and state, so each read samples `dout` 5 ns after driving the enables. That point falls before the edge at which the toggle bit flips. Expected array contents are held in a bench model and updated by AND for a program and by aligned ranges for an erase.

// File: rtl/fce_pkg.sv
package fce_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PRG_WAIT,
        ST_ERS_SET,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_BUSY_PRG,
        ST_BUSY_ERS
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_WORD,
        OP_SECTOR,
        OP_BLOCK,
        OP_CHIP
    } op_kind_t;

    localparam logic [15:0] KEY_ADDR_A    = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B    = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_A    = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B    = 8'h55;
    localparam logic [7:0]  CMD_WORD_PROG = 8'hA0;
    localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0]  CMD_SECTOR    = 8'h30;
    localparam logic [7:0]  CMD_BLOCK     = 8'h50;
    localparam logic [7:0]  CMD_CHIP      = 8'h10;

endpackage

// File: rtl/fce_strobe_filter.sv
module fce_strobe_filter #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int MIN_PULSE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int            CW   = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CMAX = CW'(MIN_PULSE);

    logic          wr_act;
    logic [CW-1:0] width;

    // a write strobe exists only with chip selected, write low, output high
    assign wr_act = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width    <= '0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (wr_act) begin
            if (width != CMAX) width <= width + 1'b1;
            wr_addr  <= addr;
            wr_data  <= din;
            wr_pulse <= 1'b0;
        end else begin
            // strobe release: accept only if it was held long enough
            wr_pulse <= (width == CMAX);
            width    <= '0;
        end
    end

    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> !$past(wr_act)) else $error("write accepted while strobe active"); // R5
    AST_SHORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_act && width != '0 && width != CMAX) |=> !wr_pulse) else $error("short strobe accepted"); // R6

endmodule

// File: rtl/fce_cmd_fsm.sv
module fce_cmd_fsm
    import fce_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 4,
    parameter int PRG_CYCLES = 20,
    parameter int ERS_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              busy_prg,
    output logic              commit,
    output op_kind_t          op_kind,
    output logic [IDX_W-1:0]  op_idx,
    output logic [DATA_W-1:0] op_data
);

    localparam int MAXC  = (PRG_CYCLES > ERS_CYCLES) ? PRG_CYCLES : ERS_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);

    seq_state_t        state, nxt;
    op_kind_t          ers_kind;
    logic              start_prg, start_ers;
    logic              hit_a, hit_b;
    logic [7:0]        cmd;
    logic [CNT_W-1:0]  cnt;

    assign hit_a = (wr_addr[15:0] == KEY_ADDR_A);
    assign hit_b = (wr_addr[15:0] == KEY_ADDR_B);
    assign cmd   = wr_data[7:0];

    always_comb begin
        nxt       = state;
        ers_kind  = OP_SECTOR;
        start_prg = 1'b0;
        start_ers = 1'b0;
        unique case (state)
            ST_IDLE:     if (wr_pulse && hit_a && cmd == KEY_DATA_A) nxt = ST_UNL1;
            ST_UNL1:     if (wr_pulse) nxt = (hit_b && cmd == KEY_DATA_B) ? ST_UNL2 : ST_IDLE;
            ST_UNL2: begin
                if (wr_pulse) begin
                    if (hit_a && cmd == CMD_WORD_PROG)      nxt = ST_PRG_WAIT;
                    else if (hit_a && cmd == CMD_ERASE_ARM) nxt = ST_ERS_SET;
                    else                                    nxt = ST_IDLE;
                end
            end
            ST_PRG_WAIT: begin
                if (wr_pulse) begin
                    nxt       = ST_BUSY_PRG;
                    start_prg = 1'b1;
                end
            end
            ST_ERS_SET:  if (wr_pulse) nxt = (hit_a && cmd == KEY_DATA_A) ? ST_ERS_UNL1 : ST_IDLE;
            ST_ERS_UNL1: if (wr_pulse) nxt = (hit_b && cmd == KEY_DATA_B) ? ST_ERS_UNL2 : ST_IDLE;
            ST_ERS_UNL2: begin
                if (wr_pulse) begin
                    nxt       = ST_BUSY_ERS;
                    start_ers = 1'b1;
                    if (cmd == CMD_SECTOR)              ers_kind = OP_SECTOR;
                    else if (cmd == CMD_BLOCK)          ers_kind = OP_BLOCK;
                    else if (cmd == CMD_CHIP && hit_a)  ers_kind = OP_CHIP;
                    else begin
                        nxt       = ST_IDLE;
                        start_ers = 1'b0;
                    end
                end
            end
            ST_BUSY_PRG, ST_BUSY_ERS: if (cnt == '0) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // operation registers and busy counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_kind <= OP_WORD;
            op_idx  <= '0;
            op_data <= '0;
        end else if (start_prg) begin
            cnt     <= CNT_W'(PRG_CYCLES - 1);
            op_kind <= OP_WORD;
            op_idx  <= wr_addr[IDX_W-1:0];
            op_data <= wr_data;
        end else if (start_ers) begin
            cnt     <= CNT_W'(ERS_CYCLES - 1);
            op_kind <= ers_kind;
            op_idx  <= wr_addr[IDX_W-1:0];
        end else if (busy && cnt != '0) begin
            cnt     <= cnt - 1'b1;
        end
    end

    assign busy     = (state == ST_BUSY_PRG) || (state == ST_BUSY_ERS);
    assign busy_prg = (state == ST_BUSY_PRG);
    assign commit   = busy && (cnt == '0);

    AST_PRG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BUSY_PRG) |-> $past(state) == ST_PRG_WAIT) else $error("program without sequence"); // R2
    AST_ERS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BUSY_ERS) |-> $past(state) == ST_ERS_UNL2) else $error("erase without sequence"); // R9
    AST_ABORT_UNL1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL1 && wr_pulse && wr_addr[15:0] != KEY_ADDR_B) |=> state == ST_IDLE) else $error("bad unlock kept"); // R4
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> busy) else $error("busy left early"); // R12
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> state == ST_IDLE) else $error("busy did not end"); // R8

endmodule

// File: rtl/fce_array_port.sv
module fce_array_port
    import fce_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int WORDS     = 16,
    parameter int SEC_WORDS = 4,
    parameter int BLK_WORDS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  op_kind_t                   op_kind,
    input  logic [$clog2(WORDS)-1:0]   op_idx,
    input  logic [DATA_W-1:0]          op_data,
    input  logic                       busy,
    input  logic                       busy_prg,
    input  logic                       ce_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [DATA_W-1:0]          dout
);

    localparam int IDX_W   = $clog2(WORDS);
    localparam int SEC_LOG = $clog2(SEC_WORDS);
    localparam int BLK_LOG = $clog2(BLK_WORDS);

    logic [DATA_W-1:0] mem [WORDS];
    logic [WORDS-1:0]  hit;
    logic [DATA_W-1:0] status;
    logic              rd_act, rd_prev, toggle;

    for (genvar i = 0; i < WORDS; i++) begin : g_hit
        localparam logic [IDX_W-1:0] WI = IDX_W'(i);
        assign hit[i] = (op_kind == OP_CHIP)
                     || (op_kind == OP_WORD   && op_idx == WI)
                     || (op_kind == OP_SECTOR && (op_idx >> SEC_LOG) == (WI >> SEC_LOG))
                     || (op_kind == OP_BLOCK  && (op_idx >> BLK_LOG) == (WI >> BLK_LOG));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WORDS; k++) mem[k] <= '1;
        end else if (commit) begin
            for (int k = 0; k < WORDS; k++)
                if (hit[k]) mem[k] <= (op_kind == OP_WORD) ? (mem[k] & op_data) : '1;
        end
    end

    assign rd_act = !ce_n && !oe_n && we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            toggle  <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            if (busy && rd_act && !rd_prev) toggle <= !toggle;
        end
    end

    always_comb begin
        status    = '0;
        status[7] = busy_prg ? !op_data[7] : 1'b0;
        status[6] = toggle;
    end

    assign dout = !rd_act ? '0 : (busy ? status : mem[rd_idx]);

    AST_TOGGLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(toggle)) else $error("toggle moved while idle"); // R7
    AST_CHIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && op_kind == OP_CHIP) |=> mem[0] == '1) else $error("chip erase left data"); // R11

endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu
    import fce_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int WORDS      = 16,
    parameter int SEC_WORDS  = 4,
    parameter int BLK_WORDS  = 8,
    parameter int PRG_CYCLES = 20,
    parameter int ERS_CYCLES = 40,
    parameter int MIN_PULSE  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int IDX_W = $clog2(WORDS);

    logic              wr_pulse;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              busy, busy_prg, commit;
    op_kind_t          op_kind;
    logic [IDX_W-1:0]  op_idx;
    logic [DATA_W-1:0] op_data;

    fce_strobe_filter #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    fce_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .PRG_CYCLES(PRG_CYCLES), .ERS_CYCLES(ERS_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .busy_prg(busy_prg), .commit(commit),
        .op_kind(op_kind), .op_idx(op_idx), .op_data(op_data)
    );

    fce_array_port #(
        .DATA_W(DATA_W), .WORDS(WORDS), .SEC_WORDS(SEC_WORDS), .BLK_WORDS(BLK_WORDS)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .op_kind(op_kind), .op_idx(op_idx), .op_data(op_data),
        .busy(busy), .busy_prg(busy_prg),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .rd_idx(addr[IDX_W-1:0]), .dout(dout)
    );

endmodule

// File: tb/flash_cmd_emu_test.sv
module flash_cmd_emu_test;

    localparam int PRG  = 20;
    localparam int ERS  = 40;
    localparam int MINP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0, din = '0;
    logic [15:0] dout;
    logic [15:0] exp_mem [16];
    logic [15:0] v;
    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    flash_cmd_emu #(
        .PRG_CYCLES(PRG), .ERS_CYCLES(ERS), .MIN_PULSE(MINP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] want);
        n_chk++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    task automatic wraw(input logic [15:0] a, input logic [15:0] d, input int len,
                        input logic ce, input logic oe);
        addr = a; din = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wstrobe(input logic [15:0] a, input logic [15:0] d, input int len);
        wraw(a, d, len, 1'b0, 1'b1);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wstrobe(a, d, MINP);
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] val);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        #5 val = dout;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock_prog();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0);
    endtask

    task automatic erase(input logic [15:0] a, input logic [7:0] code);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(a, {8'h00, code});
    endtask

    task automatic stat_pair(input string tag, input logic bit7);
        logic [15:0] s1, s2;
        rd(16'h0000, s1);
        chk({tag, " status"}, s1 & 16'hFFBF, bit7 ? 16'h0080 : 16'h0000);
        rd(16'h0000, s2);
        chk({tag, " toggle"}, (s1 ^ s2) & 16'h0040, 16'h0040);
    endtask

    task automatic sweep(input string tag);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) begin
            rd(16'(k), r);
            chk(tag, r, exp_mem[k]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) exp_mem[k] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and idle bus
        #5 chk("R1 idle bus", dout, 16'h0000);
        @(negedge clk);
        sweep("R1 reset word");

        // R2/R7: program every word, check status then data
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat = ~((16'h0001 << i) | ((i % 2 == 1) ? 16'h0080 : 16'h0000));
            unlock_prog();
            wr(16'(i), pat);
            stat_pair("R7 program", ~pat[7]);
            repeat (PRG) @(negedge clk);
            exp_mem[i] = exp_mem[i] & pat;
            rd(16'(i), v);
            chk("R2 programmed word", v, exp_mem[i]);
        end

        // R3: second program only clears bits
        unlock_prog(); wr(16'h0000, 16'h00FF);
        repeat (PRG + 2) @(negedge clk);
        exp_mem[0] = exp_mem[0] & 16'h00FF;
        rd(16'h0000, v); chk("R3 and-merge", v, exp_mem[0]);

        // R8: busy window boundary
        unlock_prog();
        wstrobe(16'h0005, 16'h0F0F, MINP);
        repeat (PRG + 1) @(negedge clk);
        rd(16'h0005, v); chk("R8 last busy cycle", v & 16'hFFBF, 16'h0080);
        exp_mem[5] = exp_mem[5] & 16'h0F0F;
        rd(16'h0005, v); chk("R8 first idle cycle", v, exp_mem[5]);

        // R4: aborted program sequences
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0056); wr(16'h5555, 16'h00A0); wr(16'h0006, 16'h0000);
        repeat (PRG + 2) @(negedge clk);
        rd(16'h0006, v); chk("R4 bad second key", v, exp_mem[6]);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5554, 16'h00A0); wr(16'h0007, 16'h0000);
        repeat (PRG + 2) @(negedge clk);
        rd(16'h0007, v); chk("R4 bad command address", v, exp_mem[7]);

        // R5: inhibited strobes while waiting for program data
        unlock_prog();
        wraw(16'h0008, 16'h0000, MINP, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        rd(16'h0008, v); chk("R5 oe low inhibits", v, exp_mem[8]);
        wraw(16'h0008, 16'h0000, MINP, 1'b1, 1'b1);
        repeat (2) @(negedge clk);
        rd(16'h0008, v); chk("R5 ce high inhibits", v, exp_mem[8]);
        wr(16'h0008, 16'h00F0);
        repeat (PRG + 2) @(negedge clk);
        exp_mem[8] = exp_mem[8] & 16'h00F0;
        rd(16'h0008, v); chk("R5 sequence survives", v, exp_mem[8]);

        // R6: minimum strobe width
        unlock_prog();
        wstrobe(16'h0009, 16'h0000, MINP - 1);
        repeat (2) @(negedge clk);
        rd(16'h0009, v); chk("R6 short strobe ignored", v, exp_mem[9]);
        wstrobe(16'h0009, 16'h3C3C, MINP);
        repeat (PRG + 2) @(negedge clk);
        exp_mem[9] = exp_mem[9] & 16'h3C3C;
        rd(16'h0009, v); chk("R6 minimum strobe accepted", v, exp_mem[9]);

        // R12: writes during busy are dropped
        unlock_prog(); wr(16'h000A, 16'hAAAA);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055);
        repeat (PRG) @(negedge clk);
        wr(16'h5555, 16'h00A0); wr(16'h000B, 16'h0000);
        repeat (PRG + 2) @(negedge clk);
        exp_mem[10] = exp_mem[10] & 16'hAAAA;
        rd(16'h000A, v); chk("R12 running program", v, exp_mem[10]);
        rd(16'h000B, v); chk("R12 busy writes ignored", v, exp_mem[11]);

        // R9: sector erase
        erase(16'h0005, 8'h30);
        stat_pair("R9 erase", 1'b0);
        repeat (ERS) @(negedge clk);
        for (int k = 4; k < 8; k++) exp_mem[k] = 16'hFFFF;
        sweep("R9 sector erase");

        // R13: aborted erase sequences
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0054); wr(16'h0000, 16'h0030);
        repeat (ERS + 2) @(negedge clk);
        rd(16'h0000, v); chk("R13 bad fifth step", v, exp_mem[0]);
        erase(16'h0001, 8'h20);
        repeat (ERS + 2) @(negedge clk);
        rd(16'h0001, v); chk("R13 unknown confirm", v, exp_mem[1]);

        // R10: block erase
        erase(16'h0009, 8'h50);
        repeat (ERS + 2) @(negedge clk);
        for (int k = 8; k < 16; k++) exp_mem[k] = 16'hFFFF;
        sweep("R10 block erase");

        // R11: chip erase
        erase(16'h5555, 8'h10);
        stat_pair("R11 erase", 1'b0);
        repeat (ERS) @(negedge clk);
        for (int k = 0; k < 16; k++) exp_mem[k] = 16'hFFFF;
        sweep("R11 chip erase");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule